// File: doc/BRIEF.md
# Processor Status Word and System Register File

This block holds a processor core's system registers. Register-move instructions reach it through one indexed write port and one indexed read port. Each port has a 5-bit index and 32-bit data. The block applies each register's own write rules. It packs the status word and the cause register into their read-back form. A few fixed identification values come back from read-only slots.

Besides the register port, the block drives the status flags the rest of the core depends on: the four integer condition flags, the interrupt level and the interrupt, trap and pending-exception controls. A 4-bit condition selector is evaluated against the current flags, so branch and set-on-condition logic can share one evaluator. A debug qualifier marks writes made by a debugger. It unlocks the cause register and changes how register 31 stores negative values.

The index layout is: 0 saved exception PC, 1 saved exception status, 2 saved double-fault PC, 3 saved double-fault status, 4 cause, 5 status word, 6 identification, 7 task control, 24 cache control, 25 address-trap target, 29 and 31 general scratch, 30 constant.

Top module: `sysreg_file`

## Requirements
- R1: After reset the status word reads 0x00008000, with only the NMI-pending bit (bit 15) set. The cause register reads 0x0000FFF0, and every other writable register reads zero.
- R2: A write to the status word (index 5) or to either saved status copy (indices 1 and 3) stores the data ANDed with 0x000FF3FF.
- R3: A write to index 0, 2 or 25 stores the data with bit 0 forced to zero.
- R4: Index 6 always reads 0x00005346, index 7 always reads 0x000000E0 and index 30 always reads 0x00000004, whatever is written to them.
- R5: The cause register (index 4) reads as the double-fault code in bits 31:16 above the exception code in bits 15:0. A write to it takes effect only when the debug qualifier is high.
- R6: A write to index 31 with the debug qualifier low and data bit 31 set stores the two's-complement negation of the data.
- R7: The cache control register (index 24) keeps only bit 1 of a write and reads zero in every other bit.
- R8: Condition codes 0 to 7 evaluate, in order: OV, CY, Z, CY|Z, S, constant true, OV|S, and (OV^S)|Z.
- R9: Condition codes 8 to 15 give the inverse of codes 0 to 7.
- R10: Reading an unassigned index returns zero. Writing one changes no register.
- R11: The flag outputs follow the status word layout: Z bit 0, S bit 1, OV bit 2, CY bit 3, interrupt disable bit 12, address-trap enable bit 13, exception pending bit 14, NMI pending bit 15, interrupt level bits 19:16.
- R12: Index 29 stores any write unchanged, and index 31 does so for debug writes and for non-negative data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 5 | Write register index |
| wr_data | input | 32 | Write data |
| dbg | input | 1 | Debug qualifier for the current write |
| rd_idx | input | 5 | Read register index |
| rd_data | output | 32 | Combinational read data |
| cond_code | input | 4 | Condition selector |
| cond_true | output | 1 | Result of the selected condition |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_ov | output | 1 | Overflow flag |
| flag_cy | output | 1 | Carry flag |
| int_dis | output | 1 | Interrupt disable |
| trap_en | output | 1 | Address-trap enable |
| exc_pend | output | 1 | Exception pending |
| nmi_pend | output | 1 | NMI pending |
| int_level | output | 4 | Current interrupt level |

## Verification
The register path is driven with all-ones data, with mixed patterns and with data whose sign bit is set. All-ones data exposes each write mask. Mixed patterns catch mis-placed field boundaries. Sign-bit data separates the negating path from the pass-through path, and the debug and non-debug forms of the same write are paired so the qualifier's effect is visible on its own. The condition evaluator is swept over all sixteen selector values for every combination of the four integer flags, which tells each code apart from every other and from its inverse.

// File: rtl/sysreg_file.sv
module sysreg_file #(
  parameter int DW = 32,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          dbg,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  input  logic [3:0]    cond_code,
  output logic          cond_true,
  output logic          flag_z,
  output logic          flag_s,
  output logic          flag_ov,
  output logic          flag_cy,
  output logic          int_dis,
  output logic          trap_en,
  output logic          exc_pend,
  output logic          nmi_pend,
  output logic [3:0]    int_level
);
  localparam logic [IW-1:0] I_EPC  = IW'(0),  I_EPS  = IW'(1),  I_DPC = IW'(2),
                            I_DPS  = IW'(3),  I_CAUS = IW'(4),  I_ST  = IW'(5),
                            I_IDN  = IW'(6),  I_TCTL = IW'(7),  I_CC  = IW'(24),
                            I_TRAP = IW'(25), I_SCR  = IW'(29), I_K30 = IW'(30),
                            I_ABS  = IW'(31);
  localparam logic [DW-1:0] ST_MASK  = DW'(32'h000F_F3FF);
  localparam logic [DW-1:0] PC_MASK  = ~DW'(1);
  localparam logic [DW-1:0] ST_RESET = DW'(32'h0000_8000);
  localparam logic [15:0]   EC_RESET = 16'hFFF0;

  logic [DW-1:0] epc_q, eps_q, dpc_q, dps_q, st_q, trap_q, scr_q, abs_q;
  logic [15:0]   dcode_q, ecode_q;
  logic          icache_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q <= '0; eps_q <= '0; dpc_q <= '0; dps_q <= '0;
      trap_q <= '0; scr_q <= '0; abs_q <= '0;
      st_q <= ST_RESET;
      dcode_q <= '0; ecode_q <= EC_RESET;
      icache_en_q <= 1'b0;
    end else if (wr_en) begin
      case (wr_idx)
        I_EPC:  epc_q  <= wr_data & PC_MASK;
        I_DPC:  dpc_q  <= wr_data & PC_MASK;
        I_TRAP: trap_q <= wr_data & PC_MASK;
        I_EPS:  eps_q  <= wr_data & ST_MASK;
        I_DPS:  dps_q  <= wr_data & ST_MASK;
        I_ST:   st_q   <= wr_data & ST_MASK;
        I_SCR:  scr_q  <= wr_data;
        I_ABS:  abs_q  <= (!dbg && wr_data[DW-1]) ? -wr_data : wr_data;
        I_CC:   icache_en_q <= wr_data[1];
        I_CAUS: if (dbg) begin
                  dcode_q <= wr_data[31:16];
                  ecode_q <= wr_data[15:0];
                end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_idx)
      I_EPC:   rd_data = epc_q;
      I_EPS:   rd_data = eps_q;
      I_DPC:   rd_data = dpc_q;
      I_DPS:   rd_data = dps_q;
      I_CAUS:  rd_data = {dcode_q, ecode_q};
      I_ST:    rd_data = st_q;
      I_IDN:   rd_data = DW'(32'h0000_5346);
      I_TCTL:  rd_data = DW'(32'h0000_00E0);
      I_CC:    rd_data = DW'({icache_en_q, 1'b0});
      I_TRAP:  rd_data = trap_q;
      I_SCR:   rd_data = scr_q;
      I_K30:   rd_data = DW'(32'h0000_0004);
      I_ABS:   rd_data = abs_q;
      default: rd_data = '0;
    endcase
  end

  assign flag_z    = st_q[0];
  assign flag_s    = st_q[1];
  assign flag_ov   = st_q[2];
  assign flag_cy   = st_q[3];
  assign int_dis   = st_q[12];
  assign trap_en   = st_q[13];
  assign exc_pend  = st_q[14];
  assign nmi_pend  = st_q[15];
  assign int_level = st_q[19:16];

  logic [7:0] cond_base;
  assign cond_base = {(flag_ov ^ flag_s) | flag_z, flag_ov | flag_s, 1'b1, flag_s,
                      flag_cy | flag_z, flag_z, flag_cy, flag_ov};
  assign cond_true = cond_base[cond_code[2:0]] ^ cond_code[3];

  assert_status_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == I_ST) |=> (rd_idx != I_ST || rd_data == ($past(wr_data) & ST_MASK)));
  assert_pc_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == I_EPC || rd_idx == I_DPC || rd_idx == I_TRAP) |-> !rd_data[0]);
  assert_ident_const_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_idx == I_IDN |-> rd_data == DW'(32'h0000_5346));
  assert_cause_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == I_CAUS && !dbg) |=> ($stable(dcode_q) && $stable(ecode_q)));
  assert_abs_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == I_ABS && !dbg) |=> (!abs_q[DW-1] || abs_q == {1'b1, {(DW-1){1'b0}}}));
  assert_always_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cond_code == 4'd5 |-> cond_true);
  assert_never_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cond_code == 4'd13 |-> !cond_true);
endmodule

// File: tb/tb_sysreg_file.sv
module tb_sysreg_file;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;
  // fields: req[78:75] widx[74:70] wdata[69:38] dbg[37] ridx[36:32] exp[31:0]
  localparam logic [78:0] VEC [0:NV-1] = '{
    {4'd2,  5'd5,  32'hFFFFFFFF, 1'b0, 5'd5,  32'h000FF3FF}, // R2 status
    {4'd2,  5'd1,  32'hFFFFFFFF, 1'b0, 5'd1,  32'h000FF3FF}, // R2 saved copy
    {4'd2,  5'd3,  32'h12345678, 1'b0, 5'd3,  32'h00045278}, // R2 saved copy
    {4'd3,  5'd0,  32'hFFFFFFFF, 1'b0, 5'd0,  32'hFFFFFFFE}, // R3
    {4'd3,  5'd2,  32'h00000003, 1'b0, 5'd2,  32'h00000002}, // R3
    {4'd3,  5'd25, 32'h80000001, 1'b0, 5'd25, 32'h80000000}, // R3
    {4'd4,  5'd6,  32'hFFFFFFFF, 1'b1, 5'd6,  32'h00005346}, // R4
    {4'd4,  5'd7,  32'h00000000, 1'b0, 5'd7,  32'h000000E0}, // R4
    {4'd4,  5'd30, 32'hFFFFFFFF, 1'b0, 5'd30, 32'h00000004}, // R4
    {4'd5,  5'd4,  32'h11112222, 1'b1, 5'd4,  32'h11112222}, // R5 debug write
    {4'd5,  5'd4,  32'hAAAAAAAA, 1'b0, 5'd4,  32'h11112222}, // R5 blocked
    {4'd6,  5'd31, 32'hFFFFFFFE, 1'b0, 5'd31, 32'h00000002}, // R6 negate
    {4'd6,  5'd31, 32'h80000000, 1'b0, 5'd31, 32'h80000000}, // R6 most negative
    {4'd12, 5'd31, 32'hFFFFFFFE, 1'b1, 5'd31, 32'hFFFFFFFE}, // R12 debug as is
    {4'd12, 5'd31, 32'h00000007, 1'b0, 5'd31, 32'h00000007}, // R12 positive
    {4'd7,  5'd24, 32'hFFFFFFFF, 1'b0, 5'd24, 32'h00000002}, // R7
    {4'd7,  5'd24, 32'hFFFFFFFD, 1'b0, 5'd24, 32'h00000000}, // R7
    {4'd12, 5'd29, 32'hDEADBEEF, 1'b0, 5'd29, 32'hDEADBEEF}, // R12
    {4'd10, 5'd10, 32'hFFFFFFFF, 1'b0, 5'd10, 32'h00000000}, // R10 read zero
    {4'd10, 5'd21, 32'h00000001, 1'b0, 5'd29, 32'hDEADBEEF}  // R10 write ignored
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, dbg = 1'b0;
  logic [4:0] wr_idx = '0, rd_idx = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [3:0] cond_code = '0, int_level;
  logic cond_true, flag_z, flag_s, flag_ov, flag_cy, int_dis, trap_en, exc_pend, nmi_pend;
  int n_chk = 0, n_fail = 0;

  sysreg_file dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .dbg(dbg), .rd_idx(rd_idx), .rd_data(rd_data),
    .cond_code(cond_code), .cond_true(cond_true), .flag_z(flag_z), .flag_s(flag_s),
    .flag_ov(flag_ov), .flag_cy(flag_cy), .int_dis(int_dis), .trap_en(trap_en),
    .exc_pend(exc_pend), .nmi_pend(nmi_pend), .int_level(int_level));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] i, input logic [31:0] d, input logic g);
    @(negedge clk); wr_en = 1'b1; wr_idx = i; wr_data = d; dbg = g;
    @(negedge clk); wr_en = 1'b0; dbg = 1'b0;
  endtask

  task automatic rd(input logic [4:0] i, output logic [31:0] d);
    rd_idx = i; #1; d = rd_data;
  endtask

  task automatic reset_check();
    logic [31:0] v;
    rd(5'd5, v);  chk("R1 status", v, 32'h00008000);
    rd(5'd4, v);  chk("R1 cause", v, 32'h0000FFF0);
    rd(5'd0, v);  chk("R1 epc", v, 32'h0);
    rd(5'd29, v); chk("R1 scratch", v, 32'h0);
    rd(5'd31, v); chk("R1 reg31", v, 32'h0);
    rd(5'd24, v); chk("R1 cache ctl", v, 32'h0);
    chk("R1 nmi flag", {31'b0, nmi_pend}, 32'h1);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (2) @(negedge clk);
    reset_check();
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < NV; k++) begin
      wr(VEC[k][74:70], VEC[k][69:38], VEC[k][37]);
      rd(VEC[k][36:32], v);
      chk($sformatf("R%0d vec%0d", VEC[k][78:75], k), v, VEC[k][31:0]);
    end
    // R11 flag positions
    wr(5'd5, 32'h0003_5009, 1'b0);
    chk("R11 flags", {20'b0, int_level, nmi_pend, exc_pend, trap_en, int_dis,
                      flag_cy, flag_ov, flag_s, flag_z},
                     {20'b0, 4'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1});
    wr(5'd5, 32'h00FA_A0F6, 1'b0);
    chk("R11 flags b", {20'b0, int_level, nmi_pend, exc_pend, trap_en, int_dis,
                        flag_cy, flag_ov, flag_s, flag_z},
                       {20'b0, 4'hA, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0});
    // R8 and R9: all flag combinations against all codes
    for (int p = 0; p < 16; p++) begin
      logic z, s, ov, cy, e;
      z = p[0]; s = p[1]; ov = p[2]; cy = p[3];
      wr(5'd5, {28'b0, cy, ov, s, z}, 1'b0);
      for (int c = 0; c < 16; c++) begin
        case (c % 8)
          0: e = ov;       1: e = cy;       2: e = z;       3: e = cy | z;
          4: e = s;        5: e = 1'b1;     6: e = ov | s;  default: e = (ov ^ s) | z;
        endcase
        if (c >= 8) e = ~e;
        cond_code = 4'(c); #1;
        chk(c < 8 ? "R8 cond" : "R9 cond", {28'b0, p[3:0]} << 8 | {27'b0, cond_true, 4'(c)},
            {28'b0, p[3:0]} << 8 | {27'b0, e, 4'(c)});
      end
    end
    // R1 again after a reset following writes
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    reset_check();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule